// File: doc/BRIEF.md
# Hot-Plug Slot Command Controller

This block executes the commands that software issues to a bank of hot-plug slots. A command is an 8-bit code with a 5-bit slot target. The controller decodes the code into a requested slot state plus power-LED and attention-LED actions. It applies legal transitions to a per-slot status record, refuses illegal ones, and reports the outcome in a small command status word. A one-cycle completion pulse ends every command.

Commands enter on a valid/ready pair. `cmd_ready_o` is high whenever the controller is idle. A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. While `cmd_ready_o` is low, a command that is offered is simply not taken, and the source must hold it. Single-slot, bus-speed and rejected commands finish in the cycle they are taken. The two all-slot commands walk the slots one per clock with busy set, and they hold `cmd_ready_o` low for the whole walk.

Each slot also tracks its latch (MRL) and card-presence inputs by edge. It latches button, latch and presence events until they are acknowledged, and it pulses a removal request when a disable command finds the power LED off.

Top module: `hp_slot_cmd_ctrl`

## Requirements
- R1: Codes 0x00-0x3F are slot commands. Bits [1:0] give the requested state (0 none, 1 power-only, 2 enabled, 3 disabled). Bits [3:2] give the power LED and bits [5:4] the attention LED (0 none, 1 on, 2 blink, 3 off). A nonzero LED field is written to the target slot.
- R2: A target of 0 or above NUM_SLOTS sets invalid-command (status bit 2) and changes no slot. Slot index is target minus 1.
- R3: A power-only request to an enabled slot sets invalid-command and changes nothing in that slot, not even its LEDs.
- R4: A disabled slot may go to power-only or enabled. A power-only or enabled slot may go to disabled. Every other requested change leaves the state as it is, with no error.
- R5: When a slot goes to disabled and its power LED, after this command's LED update, reads off: `remove_o` for that slot pulses for one cycle. The latch then reads open, presence reads 3 (empty), and the button, latch and presence events are all latched.
- R6: Codes 0x40-0x47 select bus speed from bits [2:0]. Speed 0 is accepted with clean status. Any other speed sets invalid-mode (status bit 3).
- R7: Any code outside 0x00-0x49 sets invalid-command.
- R8: Code 0x48 (all power-only) or 0x49 (all enabled) sets invalid-command and changes no slot if any slot is enabled.
- R9: Otherwise an all-slot command visits slots 0..NUM_SLOTS-1, one per clock, holding busy (status bit 0) high for NUM_SLOTS cycles. A slot whose latch is closed gets the requested state with its power LED on. A slot whose latch is open only gets its power LED turned off.
- R10: Taking a command clears status bits 0-3 before the new result. `cmd_done_o` pulses one cycle after every command, including refused ones.
- R11: A command offered while `cmd_ready_o` is low is not taken and has no effect.
- R12: After reset every slot is disabled, power LED off (3), attention LED 0, latch open, presence 3. Events, status and removal outputs are 0, and the controller is ready.
- R13: A change on `mrl_open_i` updates the slot's latch bit and latches the latch event (event bit 1). A rising `present_i` sets presence 0, and a falling one sets 3; either edge latches the presence event (bit 2). The button event is bit 0. A one on `ev_clr_i` clears the matching event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Controller idle, command will be taken |
| cmd_code_i | input | 8 | Command code |
| cmd_target_i | input | TGT_W | Slot target, 1-based |
| mrl_open_i | input | NUM_SLOTS | Per-slot latch open level |
| present_i | input | NUM_SLOTS | Per-slot card present level |
| ev_clr_i | input | 3*NUM_SLOTS | Per-slot event acknowledge, write-one-to-clear |
| slot_status_o | output | 9*NUM_SLOTS | Per slot: [1:0] state, [3:2] power LED, [5:4] attention LED, [6] latch open, [8:7] presence |
| slot_events_o | output | 3*NUM_SLOTS | Per slot: [0] button, [1] latch, [2] presence |
| remove_o | output | NUM_SLOTS | One-cycle device removal request |
| cmd_status_o | output | 4 | [0] busy, [1] latch-open error (always cleared), [2] invalid command, [3] invalid mode |
| cmd_done_o | output | 1 | One-cycle pulse when a command finishes |

## Verification
The bench targets the orderings that a simple decoder gets wrong. One is a disable-with-LED-off command, where removal depends on the LED being written before the check; a design that checked the old LED would leave the card in place. Another is a refused enabled-to-power-only request carrying an LED field; a design that applied the LEDs anyway would change the slot. Power-only-to-enabled is exercised, and must be a silent no-op; a loose transition table would enable the slot. The all-slot walk is checked for its exact busy length, its refusal when any slot is enabled, and its immunity to a command offered mid-walk.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam logic [1:0] ST_NONE = 2'd0;
  localparam logic [1:0] ST_PWR  = 2'd1;
  localparam logic [1:0] ST_EN   = 2'd2;
  localparam logic [1:0] ST_DIS  = 2'd3;

  localparam logic [1:0] LED_NONE = 2'd0;
  localparam logic [1:0] LED_ON   = 2'd1;
  localparam logic [1:0] LED_OFF  = 2'd3;

  localparam logic [1:0] PRS_LOW   = 2'd0;
  localparam logic [1:0] PRS_EMPTY = 2'd3;

  localparam int EV_BTN = 0;
  localparam int EV_MRL = 1;
  localparam int EV_PRS = 2;
  localparam int EV_W   = 3;

  localparam int CS_BUSY     = 0;
  localparam int CS_MRL      = 1;
  localparam int CS_INV_CMD  = 2;
  localparam int CS_INV_MODE = 3;

  typedef struct packed {
    logic [1:0] prsnt;
    logic       mrl_open;
    logic [1:0] attn;
    logic [1:0] pwr;
    logic [1:0] state;
  } slot_stat_t;

  localparam int STAT_W = $bits(slot_stat_t);
endpackage

// File: rtl/hpc_slot.sv
module hpc_slot
  import hpc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_en,
  input  logic [1:0]      op_state,
  input  logic [1:0]      op_pwr,
  input  logic [1:0]      op_attn,
  input  logic            mrl_open_i,
  input  logic            present_i,
  input  logic [EV_W-1:0] ev_clr_i,
  output slot_stat_t      stat_o,
  output logic [EV_W-1:0] ev_o,
  output logic            remove_o
);
  slot_stat_t      cur, nxt;
  logic [EV_W-1:0] ev_q, ev_set;
  logic            rm_q, rm_nxt;
  logic            mrl_d, prs_d;
  logic            refused;

  assign refused = (op_state == ST_PWR) && (cur.state == ST_EN);

  always_comb begin
    nxt    = cur;
    ev_set = '0;
    rm_nxt = 1'b0;
    if (mrl_open_i != mrl_d) begin
      nxt.mrl_open   = mrl_open_i;
      ev_set[EV_MRL] = 1'b1;
    end
    if (present_i != prs_d) begin
      nxt.prsnt      = present_i ? PRS_LOW : PRS_EMPTY;
      ev_set[EV_PRS] = 1'b1;
    end
    if (op_en && !refused) begin
      // LED fields land first; the removal test below sees the new LED
      if (op_pwr != LED_NONE)  nxt.pwr  = op_pwr;
      if (op_attn != LED_NONE) nxt.attn = op_attn;
      if (cur.state == ST_DIS && (op_state == ST_PWR || op_state == ST_EN)) begin
        nxt.state = op_state;
      end else if ((cur.state == ST_EN || cur.state == ST_PWR) && op_state == ST_DIS) begin
        nxt.state = ST_DIS;
        if (nxt.pwr == LED_OFF) begin
          rm_nxt       = 1'b1;
          nxt.mrl_open = 1'b1;
          nxt.prsnt    = PRS_EMPTY;
          ev_set       = '1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '{prsnt: PRS_EMPTY, mrl_open: 1'b1, attn: LED_NONE, pwr: LED_OFF, state: ST_DIS};
      ev_q  <= '0;
      rm_q  <= 1'b0;
      mrl_d <= 1'b1;
      prs_d <= 1'b0;
    end else begin
      cur   <= nxt;
      ev_q  <= (ev_q & ~ev_clr_i) | ev_set;
      rm_q  <= rm_nxt;
      mrl_d <= mrl_open_i;
      prs_d <= present_i;
    end
  end

  assign stat_o   = cur;
  assign ev_o     = ev_q;
  assign remove_o = rm_q;

  // R5: a removal request comes with an emptied, disabled, LED-off slot
  p_remove_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    remove_o |-> (cur.state == ST_DIS && cur.pwr == LED_OFF && cur.mrl_open
                  && cur.prsnt == PRS_EMPTY && ev_q == '1));

  // R3: power-only is only ever entered from disabled
  p_pwr_from_dis_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.state == ST_PWR && $past(cur.state) != ST_PWR) |-> $past(cur.state) == ST_DIS);
endmodule

// File: rtl/hpc_cmd_seq.sv
module hpc_cmd_seq
  import hpc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int TGT_W     = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid_i,
  output logic                       cmd_ready_o,
  input  logic [7:0]                 cmd_code_i,
  input  logic [TGT_W-1:0]           cmd_target_i,
  input  logic [NUM_SLOTS-1:0][1:0]  slot_state_i,
  input  logic [NUM_SLOTS-1:0]       slot_mrl_i,
  output logic [NUM_SLOTS-1:0]       op_en_o,
  output logic [1:0]                 op_state_o,
  output logic [1:0]                 op_pwr_o,
  output logic [1:0]                 op_attn_o,
  output logic [3:0]                 cmd_status_o,
  output logic                       cmd_done_o
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       walk_st_q;
  logic [3:0]       cs_q;
  logic             accept, any_en, tgt_ok;
  logic             inv_cmd, inv_mode, walk_go;
  logic [TGT_W-1:0] tidx;

  assign cmd_ready_o = !busy_q;
  assign accept      = cmd_valid_i && !busy_q;
  assign tidx        = cmd_target_i - TGT_W'(1);
  assign tgt_ok      = (cmd_target_i != '0) && (cmd_target_i <= TGT_W'(NUM_SLOTS));

  always_comb begin
    any_en = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_state_i[s] == ST_EN) any_en = 1'b1;
    end
  end

  always_comb begin
    op_en_o    = '0;
    op_state_o = ST_NONE;
    op_pwr_o   = LED_NONE;
    op_attn_o  = LED_NONE;
    inv_cmd    = 1'b0;
    inv_mode   = 1'b0;
    walk_go    = 1'b0;
    if (busy_q) begin
      op_en_o[idx_q] = 1'b1;
      if (slot_mrl_i[idx_q]) begin
        op_pwr_o = LED_OFF;
      end else begin
        op_state_o = walk_st_q;
        op_pwr_o   = LED_ON;
      end
    end else if (accept) begin
      if (cmd_code_i[7:6] == 2'b00) begin
        if (!tgt_ok) begin
          inv_cmd = 1'b1;
        end else if (cmd_code_i[1:0] == ST_PWR && slot_state_i[tidx[IDX_W-1:0]] == ST_EN) begin
          inv_cmd = 1'b1;
        end else begin
          op_en_o[tidx[IDX_W-1:0]] = 1'b1;
          op_state_o = cmd_code_i[1:0];
          op_pwr_o   = cmd_code_i[3:2];
          op_attn_o  = cmd_code_i[5:4];
        end
      end else if (cmd_code_i[7:3] == 5'b01000) begin
        inv_mode = (cmd_code_i[2:0] != 3'd0);
      end else if (cmd_code_i[7:1] == 7'b0100100) begin
        if (any_en) inv_cmd = 1'b1;
        else        walk_go = 1'b1;
      end else begin
        inv_cmd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      idx_q     <= '0;
      walk_st_q <= ST_NONE;
      cs_q      <= '0;
    end else if (accept) begin
      cs_q      <= {inv_mode, inv_cmd, 1'b0, walk_go};
      busy_q    <= walk_go;
      done_q    <= !walk_go;
      idx_q     <= '0;
      walk_st_q <= cmd_code_i[0] ? ST_EN : ST_PWR;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q        <= 1'b0;
        cs_q[CS_BUSY] <= 1'b0;
        done_q        <= 1'b1;
      end else begin
        idx_q  <= idx_q + IDX_W'(1);
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign cmd_status_o = cs_q;
  assign cmd_done_o   = done_q;

  // R1: at most one slot receives an operation per cycle
  p_one_slot_r1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(op_en_o));

  // R9: the walk advances exactly one slot per clock
  p_walk_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> idx_q == $past(idx_q) + IDX_W'(1));

  // R10: the end of a walk raises the completion pulse
  p_walk_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R10: a freshly taken command never reports the latch error bit
  p_status_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cs_q[CS_MRL]);
endmodule

// File: rtl/hp_slot_cmd_ctrl.sv
module hp_slot_cmd_ctrl
  import hpc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int TGT_W     = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid_i,
  output logic                        cmd_ready_o,
  input  logic [7:0]                  cmd_code_i,
  input  logic [TGT_W-1:0]            cmd_target_i,
  input  logic [NUM_SLOTS-1:0]        mrl_open_i,
  input  logic [NUM_SLOTS-1:0]        present_i,
  input  logic [EV_W*NUM_SLOTS-1:0]   ev_clr_i,
  output logic [STAT_W*NUM_SLOTS-1:0] slot_status_o,
  output logic [EV_W*NUM_SLOTS-1:0]   slot_events_o,
  output logic [NUM_SLOTS-1:0]        remove_o,
  output logic [3:0]                  cmd_status_o,
  output logic                        cmd_done_o
);
  logic [NUM_SLOTS-1:0][1:0] st_vec;
  logic [NUM_SLOTS-1:0]      mrl_vec;
  logic [NUM_SLOTS-1:0]      op_en;
  logic [1:0]                op_state, op_pwr, op_attn;
  slot_stat_t                stat [NUM_SLOTS];

  hpc_cmd_seq #(.NUM_SLOTS(NUM_SLOTS), .TGT_W(TGT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .cmd_code_i   (cmd_code_i),
    .cmd_target_i (cmd_target_i),
    .slot_state_i (st_vec),
    .slot_mrl_i   (mrl_vec),
    .op_en_o      (op_en),
    .op_state_o   (op_state),
    .op_pwr_o     (op_pwr),
    .op_attn_o    (op_attn),
    .cmd_status_o (cmd_status_o),
    .cmd_done_o   (cmd_done_o)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    hpc_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_en      (op_en[g]),
      .op_state   (op_state),
      .op_pwr     (op_pwr),
      .op_attn    (op_attn),
      .mrl_open_i (mrl_open_i[g]),
      .present_i  (present_i[g]),
      .ev_clr_i   (ev_clr_i[g*EV_W +: EV_W]),
      .stat_o     (stat[g]),
      .ev_o       (slot_events_o[g*EV_W +: EV_W]),
      .remove_o   (remove_o[g])
    );
    assign st_vec[g]                         = stat[g].state;
    assign mrl_vec[g]                        = stat[g].mrl_open;
    assign slot_status_o[g*STAT_W +: STAT_W] = stat[g];
  end
endmodule

// File: tb/sim_hp_slot_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_cmd_ctrl;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic         ready;
  logic [7:0]   code = 8'h00;
  logic [4:0]   tgt = 5'd0;
  logic [N-1:0] mrl_i = '1;
  logic [N-1:0] prs_i = '0;
  logic [3*N-1:0] ev_clr = '0;
  logic [9*N-1:0] ss;
  logic [3*N-1:0] ev;
  logic [N-1:0]   rem;
  logic [3:0]     cs;
  logic           done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hp_slot_cmd_ctrl #(.NUM_SLOTS(N), .TGT_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_code_i(code), .cmd_target_i(tgt), .mrl_open_i(mrl_i), .present_i(prs_i),
    .ev_clr_i(ev_clr), .slot_status_o(ss), .slot_events_o(ev), .remove_o(rem),
    .cmd_status_o(cs), .cmd_done_o(done)
  );

  function automatic int f_st(int s);   return int'(ss[s*9 +: 2]);   endfunction
  function automatic int f_pwr(int s);  return int'(ss[s*9+2 +: 2]); endfunction
  function automatic int f_attn(int s); return int'(ss[s*9+4 +: 2]); endfunction
  function automatic int f_mrl(int s);  return int'(ss[s*9+6]);      endfunction
  function automatic int f_prs(int s);  return int'(ss[s*9+7 +: 2]); endfunction
  function automatic int f_ev(int s);   return int'(ev[s*3 +: 3]);   endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] c, input logic [4:0] t);
    @(negedge clk);
    valid = 1'b1; code = c; tgt = t;
    @(negedge clk);
    valid = 1'b0;
  endtask

  // counts busy negedges; optionally offers a command during the walk
  task automatic wait_walk(input bit inject, output int n);
    n = 0;
    while (!ready && n < 100) begin
      n++;
      if (inject && n == 1) begin valid = 1'b1; code = 8'h03; tgt = 5'd1; end
      else valid = 1'b0;
      @(negedge clk);
    end
    valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < N; s++) begin
      chk("R12 state", f_st(s), 3);
      chk("R12 pwr led", f_pwr(s), 3);
      chk("R12 attn led", f_attn(s), 0);
      chk("R12 mrl", f_mrl(s), 1);
      chk("R12 presence", f_prs(s), 3);
      chk("R12 events", f_ev(s), 0);
    end
    chk("R12 status", int'(cs), 0);
    chk("R12 ready", int'(ready), 1);
    chk("R12 remove", int'(rem), 0);
  endtask

  task automatic t_insert;
    @(negedge clk);
    mrl_i[2:0] = 3'b000; prs_i[2:0] = 3'b111;
    @(negedge clk);
    for (int s = 0; s < 3; s++) begin
      chk("R13 mrl closed", f_mrl(s), 0);
      chk("R13 presence low", f_prs(s), 0);
      chk("R13 events latch+presence", f_ev(s), 6);
    end
    ev_clr = '1;
    @(negedge clk);
    ev_clr = '0;
    chk("R13 events cleared", f_ev(0), 0);
  endtask

  task automatic t_enable_leds;
    issue(8'h26, 5'd1);
    chk("R4 disabled to enabled", f_st(0), 2);
    chk("R1 power led on", f_pwr(0), 1);
    chk("R1 attn led blink", f_attn(0), 2);
    chk("R10 done pulse", int'(done), 1);
    chk("R10 status clean", int'(cs), 0);
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
  endtask

  task automatic t_refuse_pwr;
    issue(8'h0D, 5'd1);
    chk("R3 invalid cmd", int'(cs), 4);
    chk("R3 state kept", f_st(0), 2);
    chk("R3 led kept", f_pwr(0), 1);
    chk("R10 done on refused", int'(done), 1);
  endtask

  task automatic t_bad_target;
    issue(8'h26, 5'd0);
    chk("R2 target zero", int'(cs), 4);
    issue(8'h26, 5'd5);
    chk("R2 target high", int'(cs), 4);
    chk("R2 slot3 untouched", f_st(3), 3);
    chk("R2 slot3 led", f_pwr(3), 3);
  endtask

  task automatic t_walk_refused(input logic [7:0] c);
    issue(c, 5'd0);
    chk("R8 walk refused", int'(cs), 4);
    chk("R8 ready at once", int'(ready), 1);
    chk("R8 slot2 untouched", f_st(2), c[0] ? 3 : 1);
  endtask

  task automatic t_speed;
    issue(8'h40, 5'd0);
    chk("R6 speed zero ok", int'(cs), 0);
    issue(8'h43, 5'd0);
    chk("R6 speed bad", int'(cs), 8);
    issue(8'h47, 5'd0);
    chk("R6 speed bad 7", int'(cs), 8);
    issue(8'h40, 5'd0);
    chk("R10 mode bit cleared", int'(cs), 0);
  endtask

  task automatic t_unknown;
    issue(8'h50, 5'd1);
    chk("R7 code 0x50", int'(cs), 4);
    issue(8'hFF, 5'd1);
    chk("R7 code 0xFF", int'(cs), 4);
    issue(8'h4A, 5'd1);
    chk("R7 code 0x4A", int'(cs), 4);
    chk("R7 slot0 kept", f_st(0), 2);
  endtask

  task automatic t_disable_remove;
    issue(8'h03, 5'd1);
    chk("R4 enabled to disabled", f_st(0), 3);
    chk("R5 no removal with led on", int'(rem), 0);
    chk("R5 mrl kept", f_mrl(0), 0);
    issue(8'h0F, 5'd1);
    chk("R4 disabled stays", f_st(0), 3);
    chk("R1 led off applied", f_pwr(0), 3);
    chk("R5 no removal without transition", int'(rem), 0);
    issue(8'h06, 5'd2);
    chk("R4 slot1 enabled", f_st(1), 2);
    issue(8'h0F, 5'd2);
    chk("R5 removal pulse", int'(rem), 2);
    chk("R5 slot1 disabled", f_st(1), 3);
    chk("R5 mrl open", f_mrl(1), 1);
    chk("R5 presence empty", f_prs(1), 3);
    chk("R5 events all", f_ev(1), 7);
    @(negedge clk);
    chk("R5 pulse one cycle", int'(rem), 0);
    ev_clr = '1;
    @(negedge clk);
    ev_clr = '0;
  endtask

  task automatic t_walk_pwr;
    int n;
    issue(8'h48, 5'd0);
    chk("R9 busy bit", int'(cs[0]), 1);
    wait_walk(1'b1, n);
    chk("R9 busy length", n, N);
    chk("R10 done after walk", int'(done), 1);
    chk("R10 walk status", int'(cs), 0);
    chk("R11 slot0 power-only not disabled", f_st(0), 1);
    chk("R9 slot0 led on", f_pwr(0), 1);
    chk("R9 slot2 power-only", f_st(2), 1);
    chk("R9 slot1 open stays", f_st(1), 3);
    chk("R9 slot1 led off", f_pwr(1), 3);
    chk("R9 slot3 open stays", f_st(3), 3);
  endtask

  task automatic t_walk_en;
    int n;
    issue(8'h49, 5'd0);
    wait_walk(1'b0, n);
    chk("R9 walk length en", n, N);
    chk("R4 power-only not enabled", f_st(0), 1);
    issue(8'h03, 5'd1);
    chk("R4 power-only to disabled", f_st(0), 3);
    issue(8'h49, 5'd0);
    wait_walk(1'b0, n);
    chk("R9 slot0 enabled", f_st(0), 2);
    chk("R9 slot2 kept power-only", f_st(2), 1);
  endtask

  task automatic t_mrl_edge;
    @(negedge clk);
    mrl_i[0] = 1'b1;
    @(negedge clk);
    chk("R13 mrl opened", f_mrl(0), 1);
    chk("R13 latch event", f_ev(0), 2);
    ev_clr[1] = 1'b1;
    @(negedge clk);
    ev_clr = '0;
    chk("R13 latch event cleared", f_ev(0), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_insert();
    t_enable_leds();
    t_refuse_pwr();
    t_bad_target();
    t_walk_refused(8'h49);
    t_speed();
    t_unknown();
    t_disable_remove();
    t_walk_pwr();
    t_walk_en();
    t_walk_refused(8'h48);
    t_mrl_edge();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule